// File: doc/BRIEF.md
# Signed Power-of-Two Rounding Divider

This block divides a signed two's-complement word by 2^16 and returns the nearest integer as a narrow signed result. A tie (a fraction of exactly one half) moves away from zero for both signs. The low sixteen input bits hold the fraction and are dropped once the rounding decision is made. Inputs that do not need rounding, such as words whose fraction bits are all zero, pass through unchanged.

The input word carries one guard bit above its nominal 24-bit width, so 25 bits arrive in all. The arithmetic runs on the full word, so large magnitudes cannot wrap. When the rounded quotient falls outside the signed 8-bit range, the output saturates and an overflow flag is raised. A valid strobe qualifies each input. The result, the flag and an output valid appear one clock cycle after an accepted word.

Top module: `pow2_round_div`

## Requirements
- R1: With the guard bit (bit 24) at 0, the result is bits 23..16 plus bit 15. For example, 1.1 gives 1 and 1.5 gives 2.
- R2: With the guard bit at 1 and bit 15 at 1, the floor value (bits 24..16) is incremented only when some bit in 14..0 is nonzero. So -1.1 gives -1 and -1.5 gives -2.
- R3: With the guard bit at 1 and bit 15 at 0, the result is the floor value. For example, -1.9 gives -2.
- R4: An input whose bits 15..0 are all zero, including zero itself, yields bits 24..16 unchanged.
- R5: A rounded quotient above +127 gives outWord 0x7F with outOvf at 1.
- R6: A rounded quotient below -128 gives outWord 0x80 with outOvf at 1. An input whose bits 24..15 are 1_01111110_1 yields 0x80, never 0x7F. In-range results keep outOvf at 0.
- R7: outValid equals inValid delayed by one cycle. outWord and outOvf change only in the cycle after a valid input and hold their values otherwise.
- R8: While rstN is low at a rising edge, outWord, outOvf and outValid are cleared to 0 at that edge. rstN is synchronous and active low.
- R9: A non-negative input never yields a negative result, and a negative input never yields a positive result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Qualifies inWord |
| inWord | input | 25 | Signed dividend: guard bit, 24-bit nominal word; bits 15..0 are the fraction |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outWord | output | 8 | Rounded signed quotient, saturated |
| outOvf | output | 1 | Rounded quotient was out of range |

## Verification
A wrong increment decision shows up as an off-by-one outWord in the cycle after the word is accepted. It is most visible on negative ties and near-ties, which the bench covers with directed inputs. A lost guard bit or a wrong saturation compare flips the sign of a large result, or leaves outOvf low, and this also shows one cycle after acceptance. Register enables that are stuck or leaky show as outWord changing during idle cycles, which the bench checks on every cycle without a valid input.

// File: rtl/pow2_round_pkg.sv
package pow2_round_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
  } rndStrobe_t;
endpackage

// File: rtl/pow2_round_ctrl.sv
module pow2_round_ctrl
  import pow2_round_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output rndStrobe_t strb,
  output logic       outValid
);
  always_comb begin
    strb.clear = !rstN;
    strb.load  = inValid && rstN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R7
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid)));
endmodule

// File: rtl/pow2_round_dp.sv
module pow2_round_dp
  import pow2_round_pkg::*;
#(
  parameter int W      = 25,
  parameter int FRAC_W = 16,
  parameter int OUT_W  = 8
) (
  input  logic             clk,
  input  rndStrobe_t       strb,
  input  logic [W-1:0]     inWord,
  output logic [OUT_W-1:0] outWord,
  output logic             outOvf
);
  localparam int INT_W = W - FRAC_W;
  localparam int SUM_W = INT_W + 1;
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(1 << (OUT_W-1));

  logic                    isNeg, halfBit, lowNz, incr;
  logic signed [SUM_W-1:0] floorV, sumV;
  logic                    hiOvf, loOvf;
  logic [OUT_W-1:0]        nextWord;

  always_comb begin
    isNeg   = inWord[W-1];
    halfBit = inWord[FRAC_W-1];
    lowNz   = |inWord[FRAC_W-2:0];
    // ties away from zero: negatives need a strictly-above-half fraction
    incr    = isNeg ? (halfBit && lowNz) : halfBit;
    floorV  = {inWord[W-1], inWord[W-1:FRAC_W]};
    sumV    = floorV + SUM_W'(incr);
    hiOvf   = sumV > MAX_V;
    loOvf   = sumV < MIN_V;
    if (hiOvf)      nextWord = MAX_V[OUT_W-1:0];
    else if (loOvf) nextWord = MIN_V[OUT_W-1:0];
    else            nextWord = sumV[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      outWord <= '0;
      outOvf  <= 1'b0;
    end else if (strb.load) begin
      outWord <= nextWord;
      outOvf  <= hiOvf || loOvf;
    end
  end

  // R5 R6
  sat_range_chk: assert property (@(posedge clk) disable iff (strb.clear)
    outOvf |-> (outWord == MAX_V[OUT_W-1:0] || outWord == MIN_V[OUT_W-1:0]));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (!$past(strb.load) && !$past(strb.clear)) |-> ($stable(outWord) && $stable(outOvf)));
  // R8
  reset_chk: assert property (@(posedge clk)
    strb.clear |=> (outWord == '0 && !outOvf));
  // R9
  pos_sign_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.load && !inWord[W-1]) |=> !outWord[OUT_W-1]);
  // R9
  neg_sign_chk: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.load && inWord[W-1]) |=> (outWord[OUT_W-1] || outWord == '0));
endmodule

// File: rtl/pow2_round_div.sv
module pow2_round_div
  import pow2_round_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 16,
  parameter int OUT_W  = 8,
  localparam int W = DATA_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [W-1:0]     inWord,
  output logic             outValid,
  output logic [OUT_W-1:0] outWord,
  output logic             outOvf
);
  rndStrobe_t strb;

  pow2_round_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strb(strb), .outValid(outValid)
  );

  pow2_round_dp #(.W(W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .strb(strb), .inWord(inWord), .outWord(outWord), .outOvf(outOvf)
  );
endmodule

// File: tb/pow2_round_div_bench.sv
`timescale 1ns/1ps
module pow2_round_div_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [24:0] inWord = '0;
  logic        outValid, outOvf;
  logic [7:0]  outWord;
  int total = 0, bad = 0;
  logic [7:0] lastY = '0;
  logic       lastO = 1'b0;

  always #2.5 clk = ~clk;

  pow2_round_div u_pow2_round_div (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outWord(outWord), .outOvf(outOvf)
  );

  function automatic void model(input logic [24:0] x, output logic [7:0] y, output logic o);
    longint v = $signed(x);
    longint a = (v < 0) ? -v : v;
    longint q = (a + 32768) / 65536;
    if (v < 0) q = -q;
    o = (q > 127) || (q < -128);
    if (q > 127) q = 127;
    if (q < -128) q = -128;
    y = q[7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [24:0] x, input string tag);
    logic [7:0] ey; logic eo;
    model(x, ey, eo);
    inValid = 1'b1; inWord = x;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid, "R7 valid", outValid, 1);
    chk(outWord == ey, tag, outWord, ey);
    chk(outOvf == eo, {tag, " ovf"}, outOvf, eo);
    lastY = ey; lastO = eo;
  endtask

  task automatic idle(input logic [24:0] junk);
    inValid = 1'b0; inWord = junk;
    @(negedge clk);
    chk(!outValid, "R7 idle valid", outValid, 0);
    chk(outWord == lastY && outOvf == lastO, "R7 hold", {outOvf, outWord}, {lastO, lastY});
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(!outValid && outWord == 0 && !outOvf, "R8 reset", {outValid, outOvf, outWord}, 0);
    rstN = 1'b1;
    @(negedge clk);
    apply(25'd72090, "R1 1.1");
    apply(25'd98304, "R1 1.5");
    apply(25'(-72090), "R2 -1.1");
    apply(25'(-98304), "R2 -1.5");
    apply(25'(-124518), "R3 -1.9");
    apply(25'd0, "R4 zero");
    apply(25'(-3 * 65536), "R4 -3");
    apply(25'(100 * 65536), "R4 100");
    apply(25'(127 * 65536 + 32768), "R5 127.5");
    apply(25'h0FF_FFFF, "R5 big");
    apply({1'b1, 8'h7E, 1'b1, 15'h0005}, "R6 pattern");
    apply(25'h100_0000, "R6 most neg");
    apply(25'(-128 * 65536 - 32768), "R6 -128.5");
    apply(25'(-128 * 65536 - 32767), "R6 -128.49");
    idle(25'h0AB_CDEF);
    for (int i = 0; i < 400; i++) begin
      logic [24:0] x = 25'($urandom);
      if (i % 4 == 1) x = {{9{x[24]}}, x[15:0]};
      if (i % 7 == 3) x[14:0] = '0;
      if ($urandom_range(0, 2) == 0) idle(25'($urandom));
      apply(x, "R1-9 rand");
    end
    rstN = 1'b0;
    @(negedge clk);
    chk(!outValid && outWord == 0 && !outOvf, "R8 mid reset", {outValid, outOvf, outWord}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule